// File: doc/BRIEF.md
# Dual-Rail Self-Timed Demultiplexer Tree

This block turns a fast serial bit stream into a wider parallel word. Each serial bit arrives as a token on a pair of complementary wires. A pulse on `rail_one` carries a 1 and a pulse on `rail_zero` carries a 0. The token itself marks the moment the bit is valid, so the tree needs no separate strobe or bit clock.

The tree is built only from identical two-way steering cells arranged as a binary tree of `DEPTH` levels. Each cell keeps a local toggle. It sends every token it receives to the child that the toggle selects and then flips the toggle. Tokens at the root therefore alternate between the even and odd subtrees. The cells and the leaf collector are registered on a fast sampling clock, and every level adds one register stage.

The leaf collector holds one value and one full flag per output position. Once every position holds a bit, it presents the assembled word together with a one-cycle valid strobe and starts collecting the next word. A token with both rails high at once is a protocol violation. It is dropped, and it raises a sticky error flag.

Top module: `dr_demux_tree`

## Requirements
- R1: In a sampling cycle where exactly one rail is high, the block accepts one token. The token's value is 1 when `rail_one` is high and 0 when `rail_zero` is high.
- R2: A cycle with both rails low is idle. It does not move any cell toggle and does not change the position of the next token in the word.
- R3: A cycle with both rails high drops its token, so no bit position is consumed. On the following clock edge `proto_err_o` goes to 1.
- R4: Once set, `proto_err_o` stays at 1 until reset.
- R5: Counting accepted tokens from 0 after reset, token k lands in bit (k mod W) of `word_o`, where W = 2^DEPTH.
- R6: `word_valid_o` is a one-cycle pulse. It rises once for every W accepted tokens and never before W tokens have arrived since the previous word.
- R7: Suppose the last token of a word is sampled at clock edge n. Then `word_valid_o` and the matching `word_o` appear at edge n+DEPTH.
- R8: Synchronous reset returns every cell toggle to its first child and clears all leaf flags, `word_o`, `word_valid_o` and `proto_err_o`. A partly collected word is discarded.
- R9: `DEPTH` of 1, 2 and 3 gives word widths of 2, 4 and 8 with identical cell logic.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| rail_one | input | 1 | Token pulse carrying a 1 |
| rail_zero | input | 1 | Token pulse carrying a 0 |
| word_o | output | 2^DEPTH | Assembled parallel word, held until the next word |
| word_valid_o | output | 1 | One-cycle strobe marking a new word |
| proto_err_o | output | 1 | Sticky flag for a token with both rails high |

## Verification
The assertions assume that each token is a single-cycle pulse aligned to the sampling clock. They also assume that the word-count relations hold only for tokens with exactly one rail high, so a cycle with both rails high is counted as an error and not as a bit. The stimulus keeps tokens one clock wide. It separates them by zero, one or two idle cycles, injects exactly one two-rail violation in the middle of a word, and then checks that word alignment survives it. All 256 byte values are streamed through trees of depth 1, 2 and 3 at once, and each tree's words and latencies are predicted from the recorded token sequence.

// File: rtl/dr_pkg.sv
package dr_pkg;
  // One complementary pair: t carries a 1, f carries a 0.
  typedef struct packed {
    logic t;
    logic f;
  } dr_tok_t;

  localparam dr_tok_t DR_IDLE = '{t: 1'b0, f: 1'b0};
endpackage

// File: rtl/dr_cell.sv
module dr_cell
  import dr_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  dr_tok_t in_tok,
  output dr_tok_t out0,
  output dr_tok_t out1
);
  logic sel_q;
  logic live;

  // Only a clean one-hot pair counts as a token.
  assign live = in_tok.t ^ in_tok.f;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 1'b0;
      out0  <= DR_IDLE;
      out1  <= DR_IDLE;
    end else begin
      out0 <= (live && !sel_q) ? in_tok : DR_IDLE;
      out1 <= (live &&  sel_q) ? in_tok : DR_IDLE;
      if (live) sel_q <= ~sel_q;
    end
  end
endmodule

// File: rtl/dr_collect.sv
module dr_collect
  import dr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  dr_tok_t      leaf [W],
  output logic [W-1:0] word_o,
  output logic         word_valid_o
);
  logic [W-1:0] full_q, val_q;
  logic [W-1:0] hit, val_nx, full_nx;
  logic         done;

  always_comb begin
    for (int i = 0; i < W; i++) begin
      hit[i]    = leaf[i].t ^ leaf[i].f;
      val_nx[i] = hit[i] ? leaf[i].t : val_q[i];
    end
    full_nx = full_q | hit;
    done    = &full_nx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q       <= '0;
      val_q        <= '0;
      word_o       <= '0;
      word_valid_o <= 1'b0;
    end else begin
      val_q        <= val_nx;
      word_valid_o <= done;
      if (done) begin
        word_o <= val_nx;
        full_q <= '0;
      end else begin
        full_q <= full_nx;
      end
    end
  end
endmodule

// File: rtl/dr_demux_tree.sv
module dr_demux_tree
  import dr_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rail_one,
  input  logic                  rail_zero,
  output logic [(1<<DEPTH)-1:0] word_o,
  output logic                  word_valid_o,
  output logic                  proto_err_o
);
  localparam int W     = 1 << DEPTH;
  localparam int NODES = 2 * W - 1;

  // Heap-ordered nodes: level l, position j sits at (2^l - 1) + j.
  dr_tok_t node [NODES];
  dr_tok_t leaf [W];

  assign node[0] = '{t: rail_one, f: rail_zero};

  // The child index j + s*2^l puts the root choice in the LSB of the leaf
  // position, so arrival order k maps to word bit k.
  for (genvar l = 0; l < DEPTH; l++) begin : g_lvl
    for (genvar j = 0; j < (1 << l); j++) begin : g_cell
      dr_cell u_cell (
        .clk    (clk),
        .rst    (rst),
        .in_tok (node[(1 << l) - 1 + j]),
        .out0   (node[(1 << (l + 1)) - 1 + j]),
        .out1   (node[(1 << (l + 1)) - 1 + j + (1 << l)])
      );
    end
  end

  for (genvar p = 0; p < W; p++) begin : g_leaf
    assign leaf[p] = node[W - 1 + p];
  end

  dr_collect #(.W(W)) u_collect (
    .clk          (clk),
    .rst          (rst),
    .leaf         (leaf),
    .word_o       (word_o),
    .word_valid_o (word_valid_o)
  );

  always_ff @(posedge clk) begin
    if (rst) proto_err_o <= 1'b0;
    else if (rail_one && rail_zero) proto_err_o <= 1'b1;
  end
endmodule

// File: rtl/dr_demux_tree_chk.sv
module dr_demux_tree_chk #(
  parameter int DEPTH = 3
) (
  input logic clk,
  input logic rst,
  input logic rail_one,
  input logic rail_zero,
  input logic word_valid_o,
  input logic proto_err_o
);
  logic        rst_q;
  logic [31:0] tok_cnt, wrd_cnt;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      tok_cnt <= '0;
      wrd_cnt <= '0;
    end else begin
      tok_cnt <= tok_cnt + 32'(rail_one ^ rail_zero);
      wrd_cnt <= wrd_cnt + 32'(word_valid_o);
    end
  end

  // R3
  both_rails_err_chk: assert property (@(posedge clk) disable iff (rst)
    (rail_one && rail_zero) |=> proto_err_o);

  // R4
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    proto_err_o |=> proto_err_o);

  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    word_valid_o |=> !word_valid_o);

  // R6
  enough_tokens_chk: assert property (@(posedge clk) disable iff (rst)
    word_valid_o |-> (tok_cnt >= ((wrd_cnt + 32'd1) << DEPTH)));

  // R8
  rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    rst_q |-> (!word_valid_o && !proto_err_o));
endmodule

bind dr_demux_tree dr_demux_tree_chk #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .rail_one     (rail_one),
  .rail_zero    (rail_zero),
  .word_valid_o (word_valid_o),
  .proto_err_o  (proto_err_o)
);

// File: tb/dr_demux_tree_tb.sv
module dr_demux_tree_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rail_one = 1'b0;
  logic rail_zero = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  logic [7:0] wd [3];
  logic       wv [3];
  logic       er [3];

  // R9: trees of depth 1, 2 and 3 share one stimulus.
  for (genvar g = 0; g < 3; g++) begin : gen_d
    localparam int DP = g + 1;
    logic [(1<<DP)-1:0] w;
    logic v, e;
    dr_demux_tree #(.DEPTH(DP)) u_dut (
      .clk(clk), .rst(rst), .rail_one(rail_one), .rail_zero(rail_zero),
      .word_o(w), .word_valid_o(v), .proto_err_o(e)
    );
    assign wd[g] = 8'(w);
    assign wv[g] = v;
    assign er[g] = e;
  end

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  int nbits = 0;
  int widx [3];
  bit sbits [8192];
  int tcyc  [8192];

  always @(posedge clk) cyc++;

  task automatic chk(input bit c, input string req, input int act, input int expv);
    n_chk++;
    if (!c) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic send(input bit b);
    @(negedge clk);
    rail_one = b; rail_zero = !b;
    sbits[nbits] = b; tcyc[nbits] = cyc; nbits++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rail_one = 0; rail_zero = 0;
    end
  endtask

  task automatic count_check(input string req);
    for (int d = 0; d < 3; d++)
      chk(widx[d] == (nbits >> (d + 1)), req, widx[d], nbits >> (d + 1));
  endtask

  // Word monitor: R5 content, R7 latency, R6 no early word.
  always @(negedge clk) begin
    if (!rst) begin
      for (int d = 0; d < 3; d++) begin
        if (wv[d]) begin
          int w, base;
          logic [7:0] e;
          w = 2 << d;
          base = widx[d] * w;
          if (base + w > nbits) begin
            chk(0, "R6 early word", base + w, nbits);
          end else begin
            e = '0;
            for (int b = 0; b < w; b++) e[b] = sbits[base + b];
            chk(wd[d] == e, "R5 R1 word", wd[d], e);
            chk(cyc == tcyc[base + w - 1] + d + 2, "R7 latency", cyc, tcyc[base + w - 1] + d + 2);
          end
          widx[d]++;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int d = 0; d < 3; d++) widx[d] = 0;
    repeat (4) @(negedge clk);
    for (int d = 0; d < 3; d++) begin // R8 reset state
      chk(wv[d] == 0, "R8 valid at reset", wv[d], 0);
      chk(er[d] == 0, "R8 err at reset", er[d], 0);
      chk(wd[d] == 0, "R8 word at reset", wd[d], 0);
    end
    rst = 0;

    // Phase 1: every byte back-to-back.
    for (int v = 0; v < 256; v++)
      for (int b = 0; b < 8; b++) send(v[b]);
    idle(12);
    count_check("R6 count back-to-back");
    for (int d = 0; d < 3; d++) chk(er[d] == 0, "R3 no err on clean stream", er[d], 0);

    // Phase 2: R2 idle gaps, one R3 two-rail violation mid-word.
    for (int v = 0; v < 256; v++) begin
      for (int b = 0; b < 8; b++) begin
        if (v == 100 && b == 3) begin
          @(negedge clk); rail_one = 1; rail_zero = 1;
        end
        send(((v ^ 8'h5A) >> b) & 1);
        idle((v + b) % 3);
      end
    end
    idle(12);
    count_check("R2 R3 count with gaps and dropped token");
    for (int d = 0; d < 3; d++) chk(er[d] == 1, "R4 err still set", er[d], 1);

    // Partial word then reset: R8 discards it.
    send(1); send(0); send(1);
    idle(8);
    count_check("R6 no word from partial");
    @(negedge clk); rst = 1;
    repeat (3) @(negedge clk);
    for (int d = 0; d < 3; d++) begin
      chk(er[d] == 0, "R8 err cleared", er[d], 0);
      chk(wv[d] == 0, "R8 valid cleared", wv[d], 0);
      widx[d] = 0;
    end
    nbits = 0;
    rst = 0;

    // Phase 3: alignment restarts at bit 0 after reset.
    for (int v = 0; v < 64; v++)
      for (int b = 0; b < 8; b++) send(((v * 3) >> b) & 1);
    idle(12);
    count_check("R8 realigned count");
    for (int d = 0; d < 3; d++) chk(er[d] == 0, "R8 err stays clear", er[d], 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule